// File: doc/BRIEF.md
# Dual-Source Interrupt Cause Register

This block holds the control and status state for one timer interrupt line. A cause-select bit decides which of two event sources may raise the interrupt. One source is a capture strobe. The other is an end-of-processing pulse from a monostable-style tracking unit. Both events arrive as single-cycle strobes from units outside this block.

Each source has its own sticky flag. Only the source picked by the select bit can set its flag. Software clears a flag with a two-step protocol: it reads the register while the flag is 1, then writes 0 to that flag. The interrupt request is a one-cycle pulse, raised when the enabled flag goes from 0 to 1. If an event lands in the same cycle as the clearing write, the event wins: the flag stays 1 and no pulse is produced. While the low-power input is high, both flags are held at 0.

Software reaches the block through a small synchronous read/write port that carries one 8-bit register.

Top module: `irq_cause_reg`

## Requirements
- R1: After a synchronous reset, the select bit, both flags, `irq` and `rdata` are all 0.
- R2: A read cycle loads `rdata` on the next clock edge with bits [7:3] = 0, bit 2 = select, bit 1 = capture flag and bit 0 = tracking-end flag, all taken as they stood during the read cycle. Between reads, `rdata` holds its value.
- R3: A write cycle loads the select bit from `wdata[2]`.
- R4: `cap_evt` sets the capture flag (bit 1) only while select is 0. `trk_end_evt` sets the tracking-end flag (bit 0) only while select is 1. An event for the source that is not selected leaves its flag unchanged.
- R5: Writing 1 to a flag bit leaves the flag unchanged. Writing 0 to a flag that has not been read as 1 since the last write also leaves it unchanged.
- R6: A flag clears when 0 is written to it and the last access before that write was a read that returned 1 for that flag. Any write uses up this read-as-1 condition, so a later write of 0 needs a fresh read first.
- R7: If an event sets a flag in the same cycle as a clearing write to that flag, the flag stays 1 and `irq` stays 0.
- R8: While `lp_mode` is high, both flags are 0 from the next edge onward, and any pending read-as-1 condition is discarded. The select bit is not affected.
- R9: `irq` is high for exactly the cycle after an edge at which the flag enabled by select went from 0 to 1. It is low at every other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cap_evt | input | 1 | Capture event strobe |
| trk_end_evt | input | 1 | Tracking-end event strobe |
| lp_mode | input | 1 | Low-power mode; holds both flags at 0 |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Directed sequences cover four situations:
- events for the source that is not selected, which must be ignored;
- a write of 1, and a write of 0 that was not preceded by a read, neither of which may clear a flag;
- a proper read-then-write-0 clear;
- an event colliding with a clearing write, where the flag must stay 1 and no pulse may appear.

Together these separate gating by select, the read-arming rule and the set-over-clear priority. A long run follows with random reads, writes, events and low-power pulses, each input with its own density. Every cycle of it is compared against a reference model. This run exercises overlaps the directed cases do not reach, such as a read and a write in the same cycle, the select bit flipping just as an event arrives, and low-power pulses that discard pending arming.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  // Flag index doubles as the bit position in the register.
  localparam int unsigned FLAG_TRK  = 0;
  localparam int unsigned FLAG_CAP  = 1;
  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/cause_flag.sv
// One sticky flag: set by an event, cleared by read-as-1 then write-0.
module cause_flag (
  input  logic clk,
  input  logic rst,
  input  logic lp,
  input  logic set_req,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_val,
  output logic q,
  output logic rise
);
  logic armed_q;

  // A 0->1 change happens only from a clear flag outside low power.
  assign rise = set_req && !q && !lp;

  always_ff @(posedge clk) begin
    if (rst || lp) begin
      q       <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_req)
        q <= 1'b1;                      // set wins over clear
      else if (wr_en && !wr_val && armed_q)
        q <= 1'b0;
      if (wr_en)
        armed_q <= 1'b0;                // any write consumes arming
      else if (rd_en && q)
        armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cause_irq_gen.sv
// Registered single-cycle request from the rise of the selected flag.
module cause_irq_gen #(
  parameter int unsigned NF  = 2,
  parameter int unsigned SEL1_IDX = 0,
  parameter int unsigned SEL0_IDX = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic [NF-1:0] rise,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= sel ? rise[SEL1_IDX] : rise[SEL0_IDX];
  end
endmodule

// File: rtl/cause_rd_port.sv
// Registered read data with reserved bits returned as zero.
module cause_rd_port #(
  parameter int unsigned DW      = 8,
  parameter int unsigned NF      = 2,
  parameter int unsigned SEL_POS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          sel,
  input  logic [NF-1:0] flags,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] view;

  always_comb begin
    view          = '0;
    view[NF-1:0]  = flags;
    view[SEL_POS] = sel;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= view;
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_cause_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned SEL_POS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cap_evt,
  input  logic          trk_end_evt,
  input  logic          lp_mode,
  output logic          irq
);
  localparam int unsigned NF = NUM_FLAGS;

  logic          sel_q;
  logic [NF-1:0] flag_q;
  logic [NF-1:0] flag_rise;
  logic [NF-1:0] evt_in;

  assign evt_in[FLAG_TRK] = trk_end_evt;
  assign evt_in[FLAG_CAP] = cap_evt;

  generate
    if (DW > SEL_POS + 1) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DW-1:SEL_POS+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (wr_en)  sel_q <= wdata[SEL_POS];
  end

  generate
    for (genvar gi = 0; gi < NF; gi++) begin : g_flag
      logic enabled;
      // Tracking-end flag listens while select=1, capture flag while select=0.
      assign enabled = (gi == FLAG_TRK) ? sel_q : !sel_q;
      cause_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .lp      (lp_mode),
        .set_req (evt_in[gi] && enabled),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_val  (wdata[gi]),
        .q       (flag_q[gi]),
        .rise    (flag_rise[gi])
      );
    end
  endgenerate

  cause_irq_gen #(.NF(NF), .SEL1_IDX(FLAG_TRK), .SEL0_IDX(FLAG_CAP)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel_q),
    .rise (flag_rise),
    .irq  (irq)
  );

  cause_rd_port #(.DW(DW), .NF(NF), .SEL_POS(SEL_POS)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .sel   (sel_q),
    .flags (flag_q),
    .rdata (rdata)
  );
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk (
  input logic clk,
  input logic rst,
  input logic lp,
  input logic wr_en,
  input logic wr_sel,
  input logic wr_cap,
  input logic cap_evt,
  input logic sel_q,
  input logic cap_q,
  input logic trk_q,
  input logic irq
);
  // R3
  p_sel_load_r3: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) |-> sel_q == $past(wr_sel));

  // R4
  p_cap_gated_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(cap_q) && $past(sel_q) |-> !cap_q);

  // R5
  p_write1_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    $past(cap_q) && $past(wr_en) && $past(wr_cap) && !$past(lp) |-> cap_q);

  // R7
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(cap_q) && $past(cap_evt) && !$past(sel_q) && $past(wr_en)
      && !$past(wr_cap) && !$past(lp) |-> cap_q && !irq);

  // R8
  p_lp_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(lp) |-> !cap_q && !trk_q);

  // R9
  p_irq_from_rise_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(sel_q) ? (trk_q && !$past(trk_q)) : (cap_q && !$past(cap_q))));
endmodule

bind irq_cause_reg irq_cause_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .lp      (lp_mode),
  .wr_en   (wr_en),
  .wr_sel  (wdata[SEL_POS]),
  .wr_cap  (wdata[irq_cause_pkg::FLAG_CAP]),
  .cap_evt (cap_evt),
  .sel_q   (sel_q),
  .cap_q   (flag_q[irq_cause_pkg::FLAG_CAP]),
  .trk_q   (flag_q[irq_cause_pkg::FLAG_TRK]),
  .irq     (irq)
);

// File: tb/sim_irq_cause_reg.sv
`timescale 1ns/1ps
module sim_irq_cause_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cap_evt = 1'b0, trk_end_evt = 1'b0, lp_mode = 1'b0;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model state
  logic       m_sel, m_cap, m_trk, m_acap, m_atrk, m_irq;
  logic [7:0] m_rdata;

  always #5 clk = ~clk;

  irq_cause_reg u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .cap_evt(cap_evt), .trk_end_evt(trk_end_evt),
    .lp_mode(lp_mode), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] view(input logic s, input logic c, input logic t);
    return {5'b0, s, c, t};
  endfunction

  // One clock: drive, advance, step model, compare.
  task automatic cyc(input logic r, input logic w, input logic [7:0] d,
                     input logic ce, input logic te, input logic lp);
    logic cset, tset;
    rd_en = r; wr_en = w; wdata = d; cap_evt = ce; trk_end_evt = te; lp_mode = lp;
    @(posedge clk);
    cset = ce && !m_sel;
    tset = te && m_sel;
    m_irq = !lp && (m_sel ? (tset && !m_trk) : (cset && !m_cap));
    if (r) m_rdata = view(m_sel, m_cap, m_trk);
    if (lp) begin
      m_cap = 0; m_trk = 0; m_acap = 0; m_atrk = 0;
    end else begin
      logic ncap, ntrk;
      ncap = cset ? 1'b1 : ((w && !d[1] && m_acap) ? 1'b0 : m_cap);
      ntrk = tset ? 1'b1 : ((w && !d[0] && m_atrk) ? 1'b0 : m_trk);
      if (w) begin m_acap = 0; m_atrk = 0; end
      else if (r) begin
        if (m_cap) m_acap = 1;
        if (m_trk) m_atrk = 1;
      end
      m_cap = ncap; m_trk = ntrk;
    end
    if (w) m_sel = d[2];
    #2;
    chk("R9 irq vs model", irq, m_irq);
    chk("R2 rdata vs model", rdata, m_rdata);
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] exp);
    cyc(1, 0, 8'h00, 0, 0, 0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(10 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_sel = 0; m_cap = 0; m_trk = 0; m_acap = 0; m_atrk = 0; m_irq = 0; m_rdata = 0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata after reset", rdata, 0);
    chk("R1 irq after reset", irq, 0);
    rd_expect("R1 register after reset", 8'h00);

    // R3 select write
    cyc(0, 1, 8'hFC, 0, 0, 0);
    rd_expect("R3 R2 select set, reserved zero", 8'h04);

    // R4 tracking-end sets with select=1, irq pulse R9
    cyc(0, 0, 0, 0, 1, 0);
    chk("R9 irq on tracking-end rise", irq, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 irq is one cycle", irq, 0);
    rd_expect("R4 tracking flag set", 8'h05);
    // R4 capture ignored while select=1
    cyc(0, 0, 0, 1, 0, 0);
    chk("R4 no irq from unselected capture", irq, 0);
    rd_expect("R4 capture ignored", 8'h05);

    // R5 write 1 keeps; then write 0 without fresh read keeps (R6 arming consumed)
    cyc(0, 1, 8'h05, 0, 0, 0);
    cyc(0, 1, 8'h04, 0, 0, 0);
    rd_expect("R5 write-1 and unarmed write-0 keep flag", 8'h05);
    // R6 read-as-1 then write 0 clears
    cyc(0, 1, 8'h04, 0, 0, 0);
    rd_expect("R6 armed write-0 clears", 8'h04);
    // R5 write 0 with no read at all
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 1, 8'h04, 0, 0, 0);
    rd_expect("R5 unread write-0 keeps", 8'h05);

    // R7 collision: armed by read above, event with clearing write
    cyc(0, 1, 8'h04, 0, 1, 0);
    chk("R7 no irq on collision", irq, 0);
    rd_expect("R7 flag stays set", 8'h05);

    // R8 low power
    cyc(0, 0, 0, 0, 0, 1);
    rd_expect("R8 flags forced clear, select kept", 8'h04);
    cyc(0, 0, 0, 0, 1, 1);
    chk("R8 no irq during low power", irq, 0);

    // Back to capture source
    cyc(0, 1, 8'h00, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0);
    chk("R9 irq on capture rise", irq, 1);
    rd_expect("R4 only capture flag set", 8'h02);

    // Constrained random
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic r, w, ce, te, lp;
      logic [7:0] d;
      r  = ($urandom % 3) == 0;
      w  = ($urandom % 4) == 0;
      ce = ($urandom % 4) == 0;
      te = ($urandom % 4) == 0;
      lp = ($urandom % 40) == 0;
      d  = 8'($urandom);
      if (($urandom % 8) != 0) d[2] = m_sel;
      cyc(r, w, d, ce, te, lp);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule